// File: doc/BRIEF.md
# NTSC Composite Horizontal Blanking Generator

This block produces the 10-bit composite NTSC sample stream for one scan line on the 4×FSC sample grid. A free-running horizontal counter steps through the 910 sample slots of a line. In the active region (counts 0 to 767) the block forwards the incoming active-video sample. It first limits that sample so that no timing-reserved code can reach the output. In the blanking region (counts 768 to 909) it ignores the video input and builds the waveform itself, one fixed code per sample. The waveform runs through blank level, the falling sync edge, the sync tip, the rising sync edge, the color burst with its ramps, and back to blank.

The burst phase depends on a field-pair input. For the second field pair, each burst sample is the first pair's sample reflected about the blank level (0x1E0 minus the value). Three flags travel with each sample and mark the blanking span, the sync tip and the burst envelope. The counter, the sample and the flags all leave the same register stage, so they always describe the same slot. Downstream logic can therefore use `hcount` directly as the position of `sample_out`.

Top module: `ntsc_blank_gen`

## Requirements
- R1: `hcount` advances by one on every clock from 0 to 909, and goes from 909 back to 0.
- R2: While `rst_n` is low, `hcount` is 909, `sample_out` is 0x0F0, `blank_flag` is 1, and `sync_flag` and `burst_flag` are 0. The first clock after release shows count 0.
- R3: `blank_flag` is 1 exactly for counts 768 to 909. `sample_out` is 0x0F0 at counts 768–782, 854–857 and 900–909.
- R4: At counts 783, 784, 785 and 786, `sample_out` is 0x0E9, 0x0A4, 0x044 and 0x011.
- R5: `sync_flag` is 1 exactly for counts 787 to 849, and there `sample_out` is 0x010.
- R6: At counts 850, 851, 852 and 853, `sample_out` is 0x017, 0x05C, 0x0BC and 0x0EF.
- R7: `burst_flag` is 1 exactly for counts 857 to 899 (43 samples). It is never 1 with `sync_flag`, and never 1 without `blank_flag`.
- R8: With `field_alt` = 0 (fields 1/3):
  - counts 858–861 give 0x0F4, 0x0DC, 0x0D6, 0x12C;
  - counts 862–893 repeat 0x12D, 0x092, 0x0B3, 0x14E, with 0x12D at 862;
  - counts 894–899 give 0x129, 0x0A6, 0x0CD, 0x112, 0x0FA, 0x0EC.
- R9: With `field_alt` = 1 (fields 2/4), each sample at counts 858–899 is 0x1E0 minus the R8 value for that count. `field_alt` is sampled on the same clock edge that loads the count.
- R10: At counts 0–767, a `video_in` value in 0x004–0x3FB appears unchanged on `sample_out`, in the cycle whose `hcount` is the count loaded on the edge that sampled it.
- R11: At counts 0–767, a `video_in` value below 0x004 gives 0x004, and a value above 0x3FB gives 0x3FB.
- R12: `sample_out` is never in 0x000–0x003 or 0x3FC–0x3FF.
- R13: At counts 768–909, `video_in` has no effect on `sample_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4×FSC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to `clk` |
| field_alt | input | 1 | Field pair select: 0 = fields 1/3, 1 = fields 2/4 |
| video_in | input | 10 | Active-video sample |
| hcount | output | 10 | Horizontal position of the current output sample |
| sample_out | output | 10 | Composite output sample |
| blank_flag | output | 1 | High across the horizontal blanking interval |
| sync_flag | output | 1 | High across the sync tip |
| burst_flag | output | 1 | High across the burst envelope |

## Verification
The assertions check on every cycle the properties that do not depend on a table:
- the counter steps by one and wraps from 909 to 0;
- the output never carries a reserved code;
- the sync tip carries 0x010 inside blanking;
- the blanking flag tracks the count;
- the burst envelope opens only at 857 and never overlaps the tip.

Only the bench's scenarios can show the exact per-count edge, ramp and burst codes for both field pairs, the limiting of out-of-range video, and the fact that video driven during blanking is ignored. The bench compares every slot of complete lines against a table it builds from the requirements.

// File: rtl/nbw_pkg.sv
package nbw_pkg;

  localparam int unsigned SMP_W       = 10;
  localparam int unsigned LINE_SLOTS  = 910;
  localparam int unsigned CNT_W       = $clog2(LINE_SLOTS);

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Line positions (counts on the 4xFSC grid)
  localparam cnt_t H_LAST     = cnt_t'(LINE_SLOTS - 1);
  localparam cnt_t H_BLANK    = cnt_t'(768);
  localparam cnt_t H_FALL     = cnt_t'(783);
  localparam cnt_t H_TIP      = cnt_t'(787);
  localparam cnt_t H_RISE     = cnt_t'(850);
  localparam cnt_t H_BACK     = cnt_t'(854);
  localparam cnt_t H_ENV      = cnt_t'(857);
  localparam cnt_t H_RAMP_UP  = cnt_t'(858);
  localparam cnt_t H_STEADY   = cnt_t'(862);
  localparam cnt_t H_TAIL     = cnt_t'(900);

  // Levels and legal code range
  localparam smp_t LVL_BLANK  = smp_t'(10'h0F0);
  localparam smp_t LVL_TIP    = smp_t'(10'h010);
  localparam smp_t CODE_LO    = smp_t'(10'h004);
  localparam smp_t CODE_HI    = smp_t'(10'h3FB);
  localparam smp_t MIRROR_SUM = smp_t'(2 * 10'h0F0);

  typedef enum logic [2:0] {
    RG_ACTIVE,
    RG_BLANK,
    RG_FALL,
    RG_TIP,
    RG_RISE,
    RG_BURST
  } region_e;

  typedef struct packed {
    logic blank;
    logic tip;
    logic burst;
  } flags_t;

endpackage

// File: rtl/nbw_line_counter.sv
module nbw_line_counter #(
  parameter int unsigned LINE_LEN = 910,
  parameter int unsigned CW       = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);

  localparam logic [CW-1:0] LAST = CW'(LINE_LEN - 1);

  always_comb begin
    if (cnt_q == LAST) cnt_nxt = '0;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  // Reset parks on the last slot so the first live edge opens a new line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/nbw_region_dec.sv
module nbw_region_dec
  import nbw_pkg::*;
(
  input  cnt_t    cnt,
  output region_e region,
  output flags_t  flags
);

  always_comb begin
    if      (cnt < H_BLANK)   region = RG_ACTIVE;
    else if (cnt < H_FALL)    region = RG_BLANK;
    else if (cnt < H_TIP)     region = RG_FALL;
    else if (cnt < H_RISE)    region = RG_TIP;
    else if (cnt < H_BACK)    region = RG_RISE;
    else if (cnt < H_RAMP_UP) region = RG_BLANK;
    else if (cnt < H_TAIL)    region = RG_BURST;
    else                      region = RG_BLANK;
  end

  always_comb begin
    flags.blank = (cnt >= H_BLANK);
    flags.tip   = (region == RG_TIP);
    flags.burst = (cnt >= H_ENV) && (cnt < H_TAIL);
  end

endmodule

// File: rtl/nbw_blank_shapes.sv
module nbw_blank_shapes
  import nbw_pkg::*;
(
  input  cnt_t cnt,
  input  logic alt_pair,
  output smp_t edge_code,
  output smp_t burst_code
);

  smp_t       burst_base;
  logic [1:0] phase;

  // Sync edge samples, falling then rising
  always_comb begin
    unique case (cnt)
      10'd783: edge_code = 10'h0E9;
      10'd784: edge_code = 10'h0A4;
      10'd785: edge_code = 10'h044;
      10'd786: edge_code = 10'h011;
      10'd850: edge_code = 10'h017;
      10'd851: edge_code = 10'h05C;
      10'd852: edge_code = 10'h0BC;
      10'd853: edge_code = 10'h0EF;
      default: edge_code = LVL_BLANK;
    endcase
  end

  assign phase = 2'(cnt[1:0] - H_STEADY[1:0]);

  // Fields 1/3 burst: ramps from a small table, steady part from phase
  always_comb begin
    unique case (cnt)
      10'd858: burst_base = 10'h0F4;
      10'd859: burst_base = 10'h0DC;
      10'd860: burst_base = 10'h0D6;
      10'd861: burst_base = 10'h12C;
      10'd894: burst_base = 10'h129;
      10'd895: burst_base = 10'h0A6;
      10'd896: burst_base = 10'h0CD;
      10'd897: burst_base = 10'h112;
      10'd898: burst_base = 10'h0FA;
      10'd899: burst_base = 10'h0EC;
      default: begin
        unique case (phase)
          2'd0:    burst_base = 10'h12D;
          2'd1:    burst_base = 10'h092;
          2'd2:    burst_base = 10'h0B3;
          default: burst_base = 10'h14E;
        endcase
      end
    endcase
  end

  // Fields 2/4: reflection about blank level
  always_comb begin
    if (alt_pair) burst_code = MIRROR_SUM - burst_base;
    else          burst_code = burst_base;
  end

endmodule

// File: rtl/nbw_code_clip.sv
module nbw_code_clip #(
  parameter int unsigned   W  = 10,
  parameter logic [W-1:0]  LO = W'(4),
  parameter logic [W-1:0]  HI = W'((1 << W) - 5)
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_comb begin
    if      (din < LO) dout = LO;
    else if (din > HI) dout = HI;
    else               dout = din;
  end

endmodule

// File: rtl/ntsc_blank_gen.sv
module ntsc_blank_gen
  import nbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_alt,
  input  logic [SMP_W-1:0] video_in,
  output logic [CNT_W-1:0] hcount,
  output logic [SMP_W-1:0] sample_out,
  output logic             blank_flag,
  output logic             sync_flag,
  output logic             burst_flag
);

  localparam flags_t FLAGS_RST = '{blank: 1'b1, tip: 1'b0, burst: 1'b0};

  cnt_t    cnt_q;
  cnt_t    cnt_nxt;
  region_e region_nxt;
  flags_t  flg_nxt;
  flags_t  flg_q;
  smp_t    edge_code;
  smp_t    burst_code;
  smp_t    clip_code;
  smp_t    smp_nxt;
  smp_t    smp_q;

  nbw_line_counter #(
    .LINE_LEN (LINE_SLOTS),
    .CW       (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  nbw_region_dec u_region (
    .cnt    (cnt_nxt),
    .region (region_nxt),
    .flags  (flg_nxt)
  );

  nbw_blank_shapes u_shapes (
    .cnt        (cnt_nxt),
    .alt_pair   (field_alt),
    .edge_code  (edge_code),
    .burst_code (burst_code)
  );

  nbw_code_clip #(
    .W  (SMP_W),
    .LO (CODE_LO),
    .HI (CODE_HI)
  ) u_clip (
    .din  (video_in),
    .dout (clip_code)
  );

  // Next-sample select for the slot being loaded
  always_comb begin
    unique case (region_nxt)
      RG_ACTIVE:       smp_nxt = clip_code;
      RG_FALL,
      RG_RISE:         smp_nxt = edge_code;
      RG_TIP:          smp_nxt = LVL_TIP;
      RG_BURST:        smp_nxt = burst_code;
      default:         smp_nxt = LVL_BLANK;
    endcase
  end

  // Output stage, aligned with the counter register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= LVL_BLANK;
      flg_q <= FLAGS_RST;
    end else begin
      smp_q <= smp_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign hcount     = cnt_q;
  assign sample_out = smp_q;
  assign blank_flag = flg_q.blank;
  assign sync_flag  = flg_q.tip;
  assign burst_flag = flg_q.burst;

endmodule

// File: rtl/nbw_checker.sv
module nbw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] hcount,
  input logic [9:0] sample_out,
  input logic       blank_flag,
  input logic       sync_flag,
  input logic       burst_flag
);

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == 10'd909) |=> (hcount == 10'd0)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != 10'd909) |=> (hcount == $past(hcount) + 10'd1)); // R1

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out >= 10'h004) && (sample_out <= 10'h3FB)); // R12

  AST_BLANK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    blank_flag == (hcount >= 10'd768)); // R3

  AST_TIP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag |-> (sample_out == 10'h010) && blank_flag); // R5

  AST_BURST_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_flag |-> blank_flag && !sync_flag); // R7

  AST_BURST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_flag) |-> (hcount == 10'd857)); // R7

endmodule

bind ntsc_blank_gen nbw_checker u_nbw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hcount     (hcount),
  .sample_out (sample_out),
  .blank_flag (blank_flag),
  .sync_flag  (sync_flag),
  .burst_flag (burst_flag)
);

// File: tb/ntsc_blank_gen_bench.sv
module ntsc_blank_gen_bench;

  logic       clk;
  logic       rst_n;
  logic       field_alt;
  logic [9:0] video_in;
  logic [9:0] hcount;
  logic [9:0] sample_out;
  logic       blank_flag;
  logic       sync_flag;
  logic       burst_flag;

  int checks;
  int errors;
  int exp_k;

  ntsc_blank_gen u_ntsc_blank_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_alt  (field_alt),
    .video_in   (video_in),
    .hcount     (hcount),
    .sample_out (sample_out),
    .blank_flag (blank_flag),
    .sync_flag  (sync_flag),
    .burst_flag (burst_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- expected model from the requirements ----------------
  function automatic logic [9:0] limit(input logic [9:0] v);
    if (v < 10'h004) return 10'h004;   // R11
    if (v > 10'h3FB) return 10'h3FB;   // R11
    return v;                          // R10
  endfunction

  function automatic logic [9:0] burst13(input int k);
    case (k)
      858: return 10'h0F4;
      859: return 10'h0DC;
      860: return 10'h0D6;
      861: return 10'h12C;
      894: return 10'h129;
      895: return 10'h0A6;
      896: return 10'h0CD;
      897: return 10'h112;
      898: return 10'h0FA;
      899: return 10'h0EC;
      default: begin
        case ((k - 862) % 4)
          0: return 10'h12D;
          1: return 10'h092;
          2: return 10'h0B3;
          default: return 10'h14E;
        endcase
      end
    endcase
  endfunction

  function automatic logic [9:0] expect_smp(input int k, input logic alt, input logic [9:0] v);
    if (k < 768) return limit(v);
    case (k)
      783: return 10'h0E9;
      784: return 10'h0A4;
      785: return 10'h044;
      786: return 10'h011;
      850: return 10'h017;
      851: return 10'h05C;
      852: return 10'h0BC;
      853: return 10'h0EF;
      default: ;
    endcase
    if (k >= 787 && k <= 849) return 10'h010;
    if (k >= 858 && k <= 899) return alt ? (10'h1E0 - burst13(k)) : burst13(k);
    return 10'h0F0;
  endfunction

  function automatic string req_of(input int k, input logic alt);
    if (k < 768)               return "R10/R11";
    if (k >= 783 && k <= 786)  return "R4";
    if (k >= 787 && k <= 849)  return "R5";
    if (k >= 850 && k <= 853)  return "R6";
    if (k >= 858 && k <= 899)  return alt ? "R9" : "R8";
    return "R3";
  endfunction

  // ---------------- one clock with full port check ----------------
  task automatic step(input logic alt, input logic [9:0] v, input string scen);
    logic [9:0] es;
    logic       eb, et, eu;
    field_alt = alt;
    video_in  = v;
    exp_k = (exp_k == 909) ? 0 : exp_k + 1;
    @(posedge clk);
    #1;
    es = expect_smp(exp_k, alt, v);
    eb = (exp_k >= 768);
    et = (exp_k >= 787 && exp_k <= 849);
    eu = (exp_k >= 857 && exp_k <= 899);
    checks++;
    if (hcount !== 10'(exp_k)) begin
      errors++;
      $display("FAIL R1 %s: hcount=%0d expected %0d", scen, hcount, exp_k);
    end
    checks++;
    if (sample_out !== es) begin
      errors++;
      $display("FAIL %s %s count %0d: sample=%h expected %h",
               req_of(exp_k, alt), scen, exp_k, sample_out, es);
    end
    checks++;
    if ({blank_flag, sync_flag, burst_flag} !== {eb, et, eu}) begin
      errors++;
      $display("FAIL R3/R5/R7 %s count %0d: flags b/s/u=%b%b%b expected %b%b%b",
               scen, exp_k, blank_flag, sync_flag, burst_flag, eb, et, eu);
    end
    checks++;
    if (sample_out < 10'h004 || sample_out > 10'h3FB) begin
      errors++;
      $display("FAIL R12 %s count %0d: sample=%h expected within 004..3FB",
               scen, exp_k, sample_out);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset(input string scen);
    rst_n     = 1'b0;
    field_alt = 1'b0;
    video_in  = 10'h000;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (hcount !== 10'd909 || sample_out !== 10'h0F0 ||
        {blank_flag, sync_flag, burst_flag} !== 3'b100) begin
      errors++;
      $display("FAIL R2 %s: hcount=%0d sample=%h flags=%b%b%b expected 909 0f0 100",
               scen, hcount, sample_out, blank_flag, sync_flag, burst_flag);
    end
    @(negedge clk);
    rst_n = 1'b1;
    exp_k = 909;
  endtask

  // Full line; video during blanking driven to extremes (R13)
  task automatic t_line(input logic alt, input string scen);
    for (int i = 0; i < 910; i++) begin
      int k;
      logic [9:0] v;
      k = (exp_k == 909) ? 0 : exp_k + 1;
      if (k < 768) v = 10'(16 + k);
      else         v = (k % 2 == 1) ? 10'h3FF : 10'h000;
      step(alt, v, scen);
    end
  endtask

  // Out-of-range and boundary codes in the active region (R11)
  task automatic t_clip(input string scen);
    logic [9:0] pat [8];
    pat[0] = 10'h000; pat[1] = 10'h001; pat[2] = 10'h003; pat[3] = 10'h004;
    pat[4] = 10'h3FB; pat[5] = 10'h3FC; pat[6] = 10'h3FE; pat[7] = 10'h3FF;
    for (int i = 0; i < 910; i++) begin
      int k;
      k = (exp_k == 909) ? 0 : exp_k + 1;
      step(1'b0, (k < 768) ? pat[k % 8] : 10'h2AA, scen);
    end
  endtask

  // Reset in the middle of a burst, then resume from count 0 (R2)
  task automatic t_midline_reset(input string scen);
    while (exp_k != 870) step(1'b1, 10'h100, scen);
    t_reset(scen);
    step(1'b0, 10'h123, scen);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    exp_k  = 909;
    t_reset("reset state");
    t_line(1'b0, "line fields 1/3 R8 R13");
    t_line(1'b1, "line fields 2/4 R9 R13");
    t_clip("clip line R11");
    t_midline_reset("midline reset R2");
    t_line(1'b1, "line after reset R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: run not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule